// File: doc/BRIEF.md
# Partitioned SIMD Lane Compare Unit

This unit takes two 64-bit operands and compares them lane by lane. It can treat each operand as four 16-bit lanes or as two 32-bit lanes. It tests one of four conditions: greater-than, less-or-equal, not-equal or equal. The unit decodes a 32-bit instruction word itself. From the 9-bit function field of that word it picks the lane width and the condition.

Each lane gives one result bit. These bits are packed into the low end of a 64-bit integer destination value, with lane 0 in bit 0, and every other bit is cleared. The unit also passes the destination register index along with the result. If the graphics/floating-point unit is switched off, the unit raises a disabled-unit trap and writes no result. An unknown function code raises an illegal-instruction flag instead. All outputs are registered and appear one clock after the input strobe.

Top module: `simd_lane_cmp`

## Requirements
- R1: A word is accepted only when bits [31:30] are 2'b10 and bits [24:19] are 6'b110110. Any other word raises no output flag and leaves the result and destination index at zero on the following cycle.
- R2: The function field is bits [13:5]. The eight legal codes are 9'h020, 9'h022, 9'h024, 9'h026, 9'h028, 9'h02A, 9'h02C and 9'h02E. In these codes, bit 2 selects the lane width (0 = 16-bit, 1 = 32-bit). Bits {3,1} select the condition: 00 = less-or-equal, 01 = not-equal, 10 = greater-than, 11 = equal.
- R3: In 16-bit mode, lane i is operand bits [16i+15:16i]. Result bit i (i = 0..3) holds that lane's outcome, and result bits [63:4] are zero.
- R4: In 32-bit mode, lane i is operand bits [32i+31:32i]. Result bit i (i = 0..1) holds that lane's outcome, and result bits [63:2] are zero.
- R5: Greater-than and less-or-equal compare the lanes as two's-complement signed values. Less-or-equal is exactly the inverse of greater-than for each lane.
- R6: Not-equal and equal compare each lane bit for bit. Not-equal is the inverse of equal.
- R7: An accepted word with unit_en low raises out_trap_disabled alone, keeps out_valid low and leaves the result at zero. This holds even when the function code is illegal.
- R8: An accepted word with unit_en high and a function code outside R2 raises out_illegal alone, keeps out_valid low and leaves the result at zero.
- R9: Outputs appear on the cycle after in_valid. out_rd carries bits [29:25] of the accepted word. A cycle without in_valid gives all flags low on the next cycle.
- R10: A synchronous reset clears out_valid, out_trap_disabled, out_illegal, out_rd and out_result, even while in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| unit_en | input | 1 | Graphics/floating-point unit enabled |
| out_valid | output | 1 | Result valid (one cycle) |
| out_trap_disabled | output | 1 | Disabled-unit trap (one cycle) |
| out_illegal | output | 1 | Illegal function code (one cycle) |
| out_rd | output | 5 | Destination register index |
| out_result | output | 64 | Packed lane results |

## Verification
The unit has no state that lasts beyond one operation. So any wrong internal decision shows on the ports in the very next cycle. A mis-decoded width or condition shows up as a wrong packed bit or stray high bits. A faulty signed comparison only shows when lane operands straddle the sign boundary, so such operands are applied on purpose. A wrong priority between trap and illegal shows as the wrong flag. A stuck output register shows as a flag that stays high in the idle cycle that follows.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;

    localparam int WORD_W = 64;
    localparam int INSN_W = 32;
    localparam int REG_IDX_W = 5;

    // condition code formed from function-field bits {3,1}
    typedef enum logic [1:0] {
        CND_LE = 2'b00,
        CND_NE = 2'b01,
        CND_GT = 2'b10,
        CND_EQ = 2'b11
    } cond_e;

    typedef struct packed {
        logic                 hit;     // op/op3 match
        logic                 opf_ok;  // one of the eight legal codes
        logic                 wide;    // 1 = 32-bit lanes
        cond_e                cond;
        logic [REG_IDX_W-1:0] rd;
    } dec_t;

endpackage

// File: rtl/lcmp_decode.sv
module lcmp_decode
    import lcmp_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    localparam logic [1:0] OP_MATCH   = 2'b10;
    localparam logic [5:0] OP3_MATCH  = 6'b110110;
    localparam logic [4:0] OPF_PREFIX = 5'b00010;

    logic [8:0] opf;
    logic       unused_fields;

    assign opf           = insn[13:5];
    assign unused_fields = ^{insn[18:14], insn[4:0]};

    always_comb begin
        dec        = '0;
        dec.hit    = (insn[31:30] == OP_MATCH) && (insn[24:19] == OP3_MATCH);
        dec.opf_ok = (opf[8:4] == OPF_PREFIX) && !opf[0];
        dec.wide   = opf[2];
        dec.cond   = cond_e'({opf[3], opf[1]});
        dec.rd     = insn[29:25];
    end

endmodule

// File: rtl/lcmp_lanes.sv
module lcmp_lanes #(
    parameter int DW = 64,
    parameter int LW = 16,
    localparam int NL = DW / LW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [NL-1:0] gt,
    output logic [NL-1:0] eq
);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic signed [LW-1:0] la;
        logic signed [LW-1:0] lb;

        assign la    = a[i*LW +: LW];
        assign lb    = b[i*LW +: LW];
        assign gt[i] = la > lb;
        assign eq[i] = la == lb;

        always_comb begin
            if (!$isunknown({gt[i], eq[i]})) begin
                AST_GT_EQ_EXCL: assert (!(gt[i] && eq[i])); // R5
            end
        end
    end

endmodule

// File: rtl/lcmp_pack.sv
module lcmp_pack
    import lcmp_pkg::*;
#(
    parameter int DW    = 64,
    parameter int N_NAR = 4,
    parameter int N_WID = 2
) (
    input  logic [N_NAR-1:0] gt_n,
    input  logic [N_NAR-1:0] eq_n,
    input  logic [N_WID-1:0] gt_w,
    input  logic [N_WID-1:0] eq_w,
    input  logic             wide,
    input  cond_e            cond,
    output logic [DW-1:0]    result
);

    logic [N_NAR-1:0] sel_n;
    logic [N_WID-1:0] sel_w;

    always_comb begin
        case (cond)
            CND_GT: begin sel_n = gt_n;  sel_w = gt_w;  end
            CND_LE: begin sel_n = ~gt_n; sel_w = ~gt_w; end
            CND_EQ: begin sel_n = eq_n;  sel_w = eq_w;  end
            default: begin sel_n = ~eq_n; sel_w = ~eq_w; end
        endcase

        result = '0;
        if (wide) begin
            result[N_WID-1:0] = sel_w;
        end else begin
            result[N_NAR-1:0] = sel_n;
        end
    end

endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
    import lcmp_pkg::*;
#(
    parameter int DW    = WORD_W,
    parameter int NAR_W = 16,
    parameter int WID_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    insn,
    input  logic [DW-1:0]        src_a,
    input  logic [DW-1:0]        src_b,
    input  logic                 unit_en,
    output logic                 out_valid,
    output logic                 out_trap_disabled,
    output logic                 out_illegal,
    output logic [REG_IDX_W-1:0] out_rd,
    output logic [DW-1:0]        out_result
);

    localparam int N_NAR = DW / NAR_W;
    localparam int N_WID = DW / WID_W;

    typedef struct packed {
        logic                 valid;
        logic                 trap;
        logic                 illegal;
        logic                 wide;
        logic [REG_IDX_W-1:0] rd;
        logic [DW-1:0]        result;
    } out_t;

    dec_t             dec;
    logic [N_NAR-1:0] gt_n, eq_n;
    logic [N_WID-1:0] gt_w, eq_w;
    logic [DW-1:0]    packed_res;
    out_t             st_d, st_q;

    lcmp_decode u_decode (
        .insn (insn),
        .dec  (dec)
    );

    lcmp_lanes #(.DW(DW), .LW(NAR_W)) u_lanes_nar (
        .a  (src_a),
        .b  (src_b),
        .gt (gt_n),
        .eq (eq_n)
    );

    lcmp_lanes #(.DW(DW), .LW(WID_W)) u_lanes_wid (
        .a  (src_a),
        .b  (src_b),
        .gt (gt_w),
        .eq (eq_w)
    );

    lcmp_pack #(.DW(DW), .N_NAR(N_NAR), .N_WID(N_WID)) u_pack (
        .gt_n   (gt_n),
        .eq_n   (eq_n),
        .gt_w   (gt_w),
        .eq_w   (eq_w),
        .wide   (dec.wide),
        .cond   (dec.cond),
        .result (packed_res)
    );

    // next-state computation
    always_comb begin
        st_d = '0;
        if (in_valid && dec.hit) begin
            st_d.rd = dec.rd;
            if (!unit_en) begin
                st_d.trap = 1'b1;
            end else if (!dec.opf_ok) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.valid  = 1'b1;
                st_d.wide   = dec.wide;
                st_d.result = packed_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid         = st_q.valid;
    assign out_trap_disabled = st_q.trap;
    assign out_illegal       = st_q.illegal;
    assign out_rd            = st_q.rd;
    assign out_result        = st_q.result;

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_trap_disabled, out_illegal})); // R7

    AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(in_valid) && $past(unit_en))); // R9

    AST_NO_DATA_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        (out_trap_disabled || out_illegal) |-> (out_result == '0)); // R8

    AST_NAR_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result[DW-1:N_NAR] == '0)); // R3

    AST_WID_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && st_q.wide) |-> (out_result[DW-1:N_WID] == '0)); // R4

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !(out_valid || out_trap_disabled || out_illegal)); // R9

endmodule

// File: tb/simd_lane_cmp_tb.sv
`timescale 1ns/1ps
module simd_lane_cmp_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        unit_en = 1'b1;
    logic        out_valid, out_trap_disabled, out_illegal;
    logic [4:0]  out_rd;
    logic [63:0] out_result;

    int n_vec = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    simd_lane_cmp u_dut (
        .clk               (clk),
        .rst               (rst),
        .in_valid          (in_valid),
        .insn              (insn),
        .src_a             (src_a),
        .src_b             (src_b),
        .unit_en           (unit_en),
        .out_valid         (out_valid),
        .out_trap_disabled (out_trap_disabled),
        .out_illegal       (out_illegal),
        .out_rd            (out_rd),
        .out_result        (out_result)
    );

    function automatic logic [31:0] mk_insn(input logic [4:0] rd, input logic [8:0] opf);
        return {2'b10, rd, 6'b110110, 5'd3, opf, 5'd7};
    endfunction

    // independent reference: explicit opcode table
    function automatic logic [63:0] ref_cmp(input logic [8:0] opf, input logic [63:0] a,
                                            input logic [63:0] b);
        logic [63:0] r = '0;
        bit w32 = 1'b0;
        int kind = 0; // 0 gt, 1 le, 2 ne, 3 eq
        case (opf)
            9'h028: begin w32 = 0; kind = 0; end
            9'h02C: begin w32 = 1; kind = 0; end
            9'h020: begin w32 = 0; kind = 1; end
            9'h024: begin w32 = 1; kind = 1; end
            9'h022: begin w32 = 0; kind = 2; end
            9'h026: begin w32 = 1; kind = 2; end
            9'h02A: begin w32 = 0; kind = 3; end
            default: begin w32 = 1; kind = 3; end
        endcase
        if (!w32) begin
            for (int i = 0; i < 4; i++) begin
                logic signed [15:0] x = a[16*i +: 16];
                logic signed [15:0] y = b[16*i +: 16];
                case (kind)
                    0: r[i] = x > y;
                    1: r[i] = x <= y;
                    2: r[i] = x != y;
                    default: r[i] = x == y;
                endcase
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic signed [31:0] x = a[32*i +: 32];
                logic signed [31:0] y = b[32*i +: 32];
                case (kind)
                    0: r[i] = x > y;
                    1: r[i] = x <= y;
                    2: r[i] = x != y;
                    default: r[i] = x == y;
                endcase
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // drive one word, sample the registered outputs one cycle later
    task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                         input logic en);
        @(negedge clk);
        in_valid = 1'b1; insn = w; src_a = a; src_b = b; unit_en = en;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic chk_flags(input string req, input logic v, input logic t, input logic il);
        chk(req, "flags", {61'd0, out_valid, out_trap_disabled, out_illegal}, {61'd0, v, t, il});
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; insn = mk_insn(5'd9, 9'h02A); src_a = '0; src_b = '0; unit_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_flags("R10", 1'b0, 1'b0, 1'b0);
        chk("R10", "result", out_result, 64'd0);
        chk("R10", "rd", {59'd0, out_rd}, 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_all_ops;
        logic [8:0]  codes [8] = '{9'h020, 9'h022, 9'h024, 9'h026,
                                   9'h028, 9'h02A, 9'h02C, 9'h02E};
        logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;
        for (int p = 0; p < 24; p++) begin
            logic [63:0] a, b;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            a = s;
            s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
            b = (p % 3 == 0) ? a : ((p % 3 == 1) ? {a[63:32], s[31:0]} : s);
            for (int c = 0; c < 8; c++) begin
                issue(mk_insn(5'(p), codes[c]), a, b, 1'b1);
                chk_flags("R2", 1'b1, 1'b0, 1'b0);
                chk(codes[c][2] ? "R4" : "R3", "result", out_result,
                    ref_cmp(codes[c], a, b));
            end
        end
    endtask

    task automatic t_signed;
        logic [63:0] a = 64'h8000_7FFF_0001_FFFF;
        logic [63:0] b = 64'h7FFF_8000_0001_0000;
        issue(mk_insn(5'd1, 9'h028), a, b, 1'b1);
        chk("R5", "gt16", out_result, 64'h4);
        issue(mk_insn(5'd1, 9'h020), a, b, 1'b1);
        chk("R5", "le16", out_result, 64'hB);
        issue(mk_insn(5'd1, 9'h02A), a, b, 1'b1);
        chk("R6", "eq16", out_result, 64'h2);
        issue(mk_insn(5'd1, 9'h022), a, b, 1'b1);
        chk("R6", "ne16", out_result, 64'hD);
        issue(mk_insn(5'd1, 9'h02C), a, b, 1'b1);
        chk("R5", "gt32", out_result, 64'h1);
        issue(mk_insn(5'd1, 9'h024), a, b, 1'b1);
        chk("R5", "le32", out_result, 64'h2);
        issue(mk_insn(5'd1, 9'h02E), a, a, 1'b1);
        chk("R4", "eq32 all", out_result, 64'h3);
        issue(mk_insn(5'd1, 9'h02A), a, a, 1'b1);
        chk("R3", "eq16 all", out_result, 64'hF);
    endtask

    task automatic t_disabled;
        issue(mk_insn(5'd4, 9'h028), 64'hFFFF, 64'h0, 1'b0);
        chk_flags("R7", 1'b0, 1'b1, 1'b0);
        chk("R7", "result", out_result, 64'd0);
        chk("R7", "rd", {59'd0, out_rd}, 64'd4);
        issue(mk_insn(5'd4, 9'h021), 64'h0, 64'h0, 1'b0);
        chk_flags("R7", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_illegal;
        logic [8:0] bad [4] = '{9'h021, 9'h128, 9'h038, 9'h000};
        for (int k = 0; k < 4; k++) begin
            issue(mk_insn(5'd6, bad[k]), 64'h0, 64'h0, 1'b1);
            chk_flags("R8", 1'b0, 1'b0, 1'b1);
            chk("R8", "result", out_result, 64'd0);
        end
    endtask

    task automatic t_foreign;
        logic [31:0] w = mk_insn(5'd8, 9'h02A);
        issue({2'b11, w[29:0]}, 64'h0, 64'h0, 1'b1);
        chk_flags("R1", 1'b0, 1'b0, 1'b0);
        chk("R1", "result", out_result, 64'd0);
        issue({w[31:25], 6'b110100, w[18:0]}, 64'h0, 64'h0, 1'b0);
        chk_flags("R1", 1'b0, 1'b0, 1'b0);
        chk("R1", "rd", {59'd0, out_rd}, 64'd0);
    endtask

    task automatic t_latency;
        issue(mk_insn(5'd31, 9'h02E), 64'h5, 64'h5, 1'b1);
        chk_flags("R9", 1'b1, 1'b0, 1'b0);
        chk("R9", "rd", {59'd0, out_rd}, 64'd31);
        @(negedge clk);
        chk_flags("R9", 1'b0, 1'b0, 1'b0);
        chk("R9", "idle result", out_result, 64'd0);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        in_valid = 1'b1; insn = mk_insn(5'd2, 9'h02A); src_a = '0; src_b = '0; unit_en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk_flags("R10", 1'b0, 1'b0, 1'b0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_all_ops();
        t_signed();
        t_disabled();
        t_illegal();
        t_foreign();
        t_latency();
        t_reset_mid();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule